// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block decides when a capture of logic signals is triggered. After being armed it walks through up to four programmed levels. Each level waits either for a chosen event strobe a set number of times, for a set number of sample clocks, for a set number of time-base ticks, or holds indefinitely. Once the last enabled level is satisfied, the trigger is declared. An external trigger input or a manual request also declares the trigger while the sequence runs, and a time-out forces it if nothing else has fired by then.

A blanking interval counted in time-base ticks follows each arm. During that interval every strobe, the external input and the manual request are ignored. The time-out interval is counted only once blanking has ended. On the trigger cycle the block issues a one-cycle trigger pulse and a capture-memory strobe. In pre-trigger mode that strobe is a stop and capture runs from arm to trigger. In post-trigger mode it is a start and capture runs from the trigger on. The capture memory itself is outside the block.

Top module: `trig_sequencer`

## Requirements
- R1: After reset, and before the first arm, the block is idle: `trig_o`, `triggered_o`, `capture_en_o` are 0, `level_o` is 0, and strobes of any kind cause no trigger. A cycle with `arm_i` high returns the sequence to level 0 with `triggered_o` low on the next cycle.
- R2: A level of kind 1 (clock delay) is satisfied after max(C,1) sample clocks in that level, where C is its count. Level k uses `lvl_kind_i[2k+1:2k]`, `lvl_src_i[2k+1:2k]` and `lvl_count_i[16k+15:16k]`. Levels 0..`last_lvl_i` run in order, and satisfying level `last_lvl_i` declares the trigger.
- R3: A level of kind 0 (event) is satisfied on the max(C,1)-th cycle in which its selected source strobes. Source 0 is `match_i[0]`, source 1 is `match_i[1]` and source 2 is `glitch_i`. Strobes of unselected sources are not counted.
- R4: A level of kind 2 (time delay) is satisfied on the max(C,1)-th cycle with `tick_i` high. Cycles without a tick do not count.
- R5: With blanking interval T nonzero, the first T `tick_i` cycles after arm form a blanking window. Match, glitch, external and manual strobes in that window have no effect. With T = 0 the sequence runs at once.
- R6: With time-out interval O nonzero, the trigger is forced on the O-th `tick_i` cycle after blanking ends, unless it fired earlier. O = 0 disables the time-out. A time-out and a level completion in the same cycle give a single trigger.
- R7: While the sequence runs, a high `ext_trig_i` or `manual_i` declares the trigger on the next cycle.
- R8: `trig_o` is high for exactly one cycle per trigger, in the first cycle of `triggered_o`. `triggered_o` stays high and no further trigger occurs until the next arm.
- R9: `post_mode_i` is sampled at arm. In pre-trigger mode (0), `capture_en_o` is high from the cycle after arm until the trigger, and `cap_stop_o` pulses with `trig_o`. In post-trigger mode (1), `capture_en_o` rises with `trig_o` and stays high, and `cap_start_o` pulses with `trig_o`.
- R10: A level of kind 3 (hold) never advances. Only external, manual or time-out can end it.
- R11: Arming while a sequence is in progress restarts it from level 0 with all counts cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm / restart the sequence |
| post_mode_i | input | 1 | 0 = pre-trigger capture, 1 = post-trigger capture |
| last_lvl_i | input | 2 | Index of the final level |
| lvl_kind_i | input | 8 | Per-level kind, 2 bits per level |
| lvl_src_i | input | 8 | Per-level event source, 2 bits per level |
| lvl_count_i | input | 64 | Per-level count, 16 bits per level |
| time_in_i | input | 16 | Blanking interval in ticks |
| time_out_i | input | 16 | Time-out interval in ticks, 0 = off |
| tick_i | input | 1 | Time-base tick strobe |
| match_i | input | 2 | Word-match strobes |
| glitch_i | input | 1 | Glitch strobe |
| ext_trig_i | input | 1 | External trigger input |
| manual_i | input | 1 | Manual trigger request |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Trigger has occurred since arm |
| level_o | output | 2 | Current level index |
| capture_en_o | output | 1 | Capture memory write enable |
| cap_stop_o | output | 1 | Capture stop strobe (pre-trigger mode) |
| cap_start_o | output | 1 | Capture start strobe (post-trigger mode) |

## Verification
The time-out counter and the final level's count can both complete on the same cycle. The bench provokes this by sweeping clock-delay chains against time-out values. With the tick held high, some time-out values equal the chain length exactly. The arm-to-trigger distance must equal the blanking interval plus the smaller of the chain length and the time-out, and exactly one trigger pulse may appear in that case. The bench also checks that the same strobes are ignored while blanking but counted once it ends.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  typedef enum logic [1:0] {
    LK_EVENT = 2'd0,
    LK_CLOCK = 2'd1,
    LK_TICK  = 2'd2,
    LK_HOLD  = 2'd3
  } lvl_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_BLANK = 2'd1,
    SQ_RUN   = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/trig_level_ctr.sv
module trig_level_ctr
  import trig_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_EV  = 3,
  parameter int SRC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [N_EV-1:0]  ev_i,
  input  logic             tick_i,
  input  lvl_kind_e        kind_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             strobe;
  logic             reached;

  always_comb begin
    strobe = 1'b0;
    unique case (kind_i)
      LK_EVENT: begin
        for (int i = 0; i < N_EV; i++) begin
          if (src_i == SRC_W'(i)) strobe = ev_i[i];
        end
      end
      LK_CLOCK: strobe = 1'b1;
      LK_TICK:  strobe = tick_i;
      default:  strobe = 1'b0;
    endcase
  end

  // count of 0 behaves as 1
  assign reached = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, count_i};
  assign hit_o   = en_i & strobe & reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || hit_o)    cnt_q <= '0;
    else if (en_i && strobe)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/trig_window_tmr.sv
module trig_window_tmr #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              blank_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_in_i,
  input  logic [TIME_W-1:0] time_out_i,
  output logic              blank_end_o,
  output logic              timeout_o
);
  logic [TIME_W-1:0] tmr_q;
  logic [TIME_W:0]   tmr_nx;
  logic              to_en;

  assign tmr_nx      = {1'b0, tmr_q} + (TIME_W+1)'(1);
  assign to_en       = time_out_i != '0;
  assign blank_end_o = blank_i & tick_i & (tmr_nx >= {1'b0, time_in_i});
  assign timeout_o   = run_i & tick_i & to_en & (tmr_nx >= {1'b0, time_out_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       tmr_q <= '0;
    else if (clr_i || blank_end_o)     tmr_q <= '0;
    else if (blank_i && tick_i)        tmr_q <= tmr_nx[TIME_W-1:0];
    else if (run_i && tick_i && to_en && tmr_q != '1)
                                       tmr_q <= tmr_nx[TIME_W-1:0];
  end
endmodule

// File: rtl/trig_capture_ctl.sv
module trig_capture_ctl (
  input  logic trig_i,
  input  logic post_i,
  input  logic active_i,
  input  logic done_i,
  output logic cap_stop_o,
  output logic cap_start_o,
  output logic capture_en_o
);
  assign cap_stop_o   = trig_i & ~post_i;
  assign cap_start_o  = trig_i &  post_i;
  assign capture_en_o = post_i ? done_i : active_i;
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_seq_pkg::*;
#(
  parameter int N_LEVELS = 4,
  parameter int N_MATCH  = 2,
  parameter int CNT_W    = 16,
  parameter int TIME_W   = 16,
  localparam int LVL_W   = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1,
  localparam int N_EV    = N_MATCH + 1,
  localparam int SRC_W   = $clog2(N_EV),
  localparam int KIND_W  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       arm_i,
  input  logic                       post_mode_i,
  input  logic [LVL_W-1:0]           last_lvl_i,
  input  logic [N_LEVELS*KIND_W-1:0] lvl_kind_i,
  input  logic [N_LEVELS*SRC_W-1:0]  lvl_src_i,
  input  logic [N_LEVELS*CNT_W-1:0]  lvl_count_i,
  input  logic [TIME_W-1:0]          time_in_i,
  input  logic [TIME_W-1:0]          time_out_i,
  input  logic                       tick_i,
  input  logic [N_MATCH-1:0]         match_i,
  input  logic                       glitch_i,
  input  logic                       ext_trig_i,
  input  logic                       manual_i,
  output logic                       trig_o,
  output logic                       triggered_o,
  output logic [LVL_W-1:0]           level_o,
  output logic                       capture_en_o,
  output logic                       cap_stop_o,
  output logic                       cap_start_o
);
  seq_state_e       state_q;
  logic [LVL_W-1:0] level_q;
  logic             trig_q;
  logic             post_q;

  lvl_kind_e        kind_cur;
  logic [SRC_W-1:0] src_cur;
  logic [CNT_W-1:0] count_cur;
  logic             running, blanking;
  logic             lvl_hit, blank_end, timeout, fire;

  assign kind_cur  = lvl_kind_e'(lvl_kind_i[int'(level_q)*KIND_W +: KIND_W]);
  assign src_cur   = lvl_src_i[int'(level_q)*SRC_W +: SRC_W];
  assign count_cur = lvl_count_i[int'(level_q)*CNT_W +: CNT_W];
  assign running   = (state_q == SQ_RUN);
  assign blanking  = (state_q == SQ_BLANK);

  trig_level_ctr #(.CNT_W(CNT_W), .N_EV(N_EV), .SRC_W(SRC_W)) u_lvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (arm_i | ~running),
    .en_i    (running & ~arm_i),
    .ev_i    ({glitch_i, match_i}),
    .tick_i  (tick_i),
    .kind_i  (kind_cur),
    .src_i   (src_cur),
    .count_i (count_cur),
    .hit_o   (lvl_hit)
  );

  trig_window_tmr #(.TIME_W(TIME_W)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (arm_i),
    .blank_i     (blanking),
    .run_i       (running),
    .tick_i      (tick_i),
    .time_in_i   (time_in_i),
    .time_out_i  (time_out_i),
    .blank_end_o (blank_end),
    .timeout_o   (timeout)
  );

  assign fire = running & (ext_trig_i | manual_i | timeout |
                           (lvl_hit & (level_q == last_lvl_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      level_q <= '0;
      trig_q  <= 1'b0;
      post_q  <= 1'b0;
    end else if (arm_i) begin
      state_q <= (time_in_i == '0) ? SQ_RUN : SQ_BLANK;
      level_q <= '0;
      trig_q  <= 1'b0;
      post_q  <= post_mode_i;
    end else begin
      trig_q <= 1'b0;
      unique case (state_q)
        SQ_BLANK: if (blank_end) state_q <= SQ_RUN;
        SQ_RUN: begin
          if (fire) begin
            state_q <= SQ_DONE;
            trig_q  <= 1'b1;
          end else if (lvl_hit) begin
            level_q <= level_q + LVL_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  trig_capture_ctl u_cap (
    .trig_i       (trig_q),
    .post_i       (post_q),
    .active_i     (blanking | running),
    .done_i       (state_q == SQ_DONE),
    .cap_stop_o   (cap_stop_o),
    .cap_start_o  (cap_start_o),
    .capture_en_o (capture_en_o)
  );

  assign trig_o      = trig_q;
  assign triggered_o = (state_q == SQ_DONE);
  assign level_o     = level_q;

  // R8
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R8
  trig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !arm_i) |=> (triggered_o && !trig_o));
  // R1
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!triggered_o && level_o == '0 && !trig_o));
  // R5
  blank_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blanking && !arm_i) |=> !trig_o);
  // R7
  ext_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !arm_i && (ext_trig_i || manual_i)) |=> trig_o);
  // R9
  cap_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (cap_stop_o != cap_start_o));
  // R2
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> (level_q <= last_lvl_i));
endmodule

// File: tb/trig_sequencer_test.sv
module trig_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, post = 1'b0;
  logic [1:0]  last = '0;
  logic [7:0]  kind = '0;
  logic [7:0]  src = '0;
  logic [63:0] cnt = '0;
  logic [15:0] tin = '0, tout = '0;
  logic        tick = 1'b0, glitch = 1'b0, ext = 1'b0, man = 1'b0;
  logic [1:0]  match = '0;
  logic        trig_o, triggered_o, capture_en_o, cap_stop_o, cap_start_o;
  logic [1:0]  level_o;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  trig_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .post_mode_i(post),
    .last_lvl_i(last), .lvl_kind_i(kind), .lvl_src_i(src), .lvl_count_i(cnt),
    .time_in_i(tin), .time_out_i(tout), .tick_i(tick), .match_i(match),
    .glitch_i(glitch), .ext_trig_i(ext), .manual_i(man),
    .trig_o(trig_o), .triggered_o(triggered_o), .level_o(level_o),
    .capture_en_o(capture_en_o), .cap_stop_o(cap_stop_o), .cap_start_o(cap_start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lvl(input int k, input int kd, input int s, input int c);
    kind[2*k +: 2] = kd[1:0];
    src[2*k +: 2]  = s[1:0];
    cnt[16*k +: 16] = c[15:0];
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // 0/1 match, 2 glitch, 3 ext, 4 manual, 5 tick
  task automatic pulse_in(input int which);
    case (which)
      0: match[0] = 1'b1;
      1: match[1] = 1'b1;
      2: glitch = 1'b1;
      3: ext = 1'b1;
      4: man = 1'b1;
      default: tick = 1'b1;
    endcase
    @(negedge clk);
    match = '0; glitch = 1'b0; ext = 1'b0; man = 1'b0;
    if (which == 5) tick = 1'b0;
  endtask

  task automatic arm_run(output int k);
    do_arm();
    k = 0;
    while (!trig_o && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wait_trig();
    for (int i = 0; i < 100 && !trig_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int k, exp, sum;
    step(3);
    chk(!trig_o && !triggered_o && !capture_en_o && level_o == 0, "R1 reset", int'(triggered_o), 0);
    rst_n = 1'b1;
    step(1);
    pulse_in(3); pulse_in(4); pulse_in(0);
    step(2);
    chk(!triggered_o && !trig_o, "R1 idle ignores strobes", int'(triggered_o), 0);

    // sweep: clock-delay chains x blanking x time-out
    tick = 1'b1;
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < 4; c++)
        for (int t = 0; t < 3; t++)
          for (int o = 0; o < 9; o += 3) begin
            last = l[1:0];
            sum = 0;
            for (int j = 0; j < 4; j++) begin
              set_lvl(j, 1, 0, (c + j) % 4);
              if (j <= l) sum += ((c + j) % 4 == 0) ? 1 : (c + j) % 4;
            end
            tin = 16'(t); tout = 16'(o);
            exp = t + ((o != 0 && o < sum) ? o : sum);
            arm_run(k);
            chk(k == exp, "R2 R5 R6 arm-to-trigger", k, exp);
            @(negedge clk);
            chk(!trig_o && triggered_o, "R8 single pulse", int'(trig_o), 0);
          end
    tick = 1'b0; tin = '0; tout = '0;

    // R3 event counting with source selection
    last = 2'd1;
    set_lvl(0, 0, 1, 3); set_lvl(1, 0, 2, 2);
    do_arm();
    pulse_in(0); pulse_in(0); pulse_in(1); pulse_in(2); pulse_in(1);
    chk(level_o == 0, "R3 two selected strobes", int'(level_o), 0);
    pulse_in(1);
    chk(level_o == 1, "R3 third strobe advances", int'(level_o), 1);
    pulse_in(2);
    chk(!trig_o, "R3 one glitch", int'(trig_o), 0);
    pulse_in(2);
    chk(trig_o, "R3 second glitch triggers", int'(trig_o), 1);

    // R4 tick level
    last = 2'd0;
    set_lvl(0, 2, 0, 3);
    do_arm();
    step(5); pulse_in(5); step(3); pulse_in(5); step(4);
    chk(!triggered_o, "R4 two ticks", int'(triggered_o), 0);
    pulse_in(5);
    chk(trig_o, "R4 third tick triggers", int'(trig_o), 1);

    // R5 blanking ignores strobes
    set_lvl(0, 0, 0, 1);
    tin = 16'd4;
    do_arm();
    pulse_in(0); pulse_in(3); pulse_in(4); pulse_in(5); pulse_in(0);
    step(3);
    chk(!triggered_o, "R5 strobes in blanking", int'(triggered_o), 0);
    pulse_in(5); pulse_in(5);
    pulse_in(3);
    chk(!trig_o && !triggered_o, "R5 ext before last tick", int'(triggered_o), 0);
    pulse_in(5);
    pulse_in(0);
    chk(trig_o, "R5 match after blanking", int'(trig_o), 1);
    tin = '0;

    // R10 hold, R7 ext/manual, R8 no retrigger
    set_lvl(0, 3, 0, 0);
    do_arm();
    pulse_in(0); pulse_in(2); pulse_in(5);
    step(10);
    chk(!triggered_o, "R10 hold level", int'(triggered_o), 0);
    pulse_in(3);
    chk(trig_o, "R7 external trigger", int'(trig_o), 1);
    step(1);
    pulse_in(3);
    chk(!trig_o && triggered_o, "R8 no retrigger", int'(trig_o), 0);
    do_arm();
    chk(!triggered_o, "R1 re-arm clears", int'(triggered_o), 0);
    pulse_in(4);
    chk(trig_o, "R7 manual trigger", int'(trig_o), 1);
    tick = 1'b1; tout = 16'd5;
    arm_run(k);
    chk(k == 5, "R6 R10 time-out ends hold", k, 5);
    tick = 1'b0; tout = '0;

    // R9 pre-trigger
    post = 1'b0;
    set_lvl(0, 1, 0, 4);
    do_arm();
    chk(capture_en_o, "R9 pre capture running", int'(capture_en_o), 1);
    wait_trig();
    chk(cap_stop_o && !cap_start_o && !capture_en_o, "R9 pre stop strobe", int'(cap_stop_o), 1);
    step(1);
    chk(!cap_stop_o && !capture_en_o, "R9 pre after stop", int'(capture_en_o), 0);
    // R9 post-trigger
    post = 1'b1;
    do_arm();
    post = 1'b0;
    chk(!capture_en_o, "R9 post idle before trigger", int'(capture_en_o), 0);
    wait_trig();
    chk(cap_start_o && !cap_stop_o && capture_en_o, "R9 post start strobe", int'(cap_start_o), 1);
    step(1);
    chk(!cap_start_o && capture_en_o, "R9 post capture running", int'(capture_en_o), 1);

    // R11 restart mid-sequence
    last = 2'd1;
    set_lvl(0, 1, 0, 10); set_lvl(1, 1, 0, 5);
    do_arm();
    step(12);
    chk(level_o == 1, "R11 mid-sequence level", int'(level_o), 1);
    arm_run(k);
    chk(k == 15, "R11 restart full length", k, 15);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule